// File: doc/BRIEF.md
# Dual-Channel Address Mapper

This block sits at the front of a two-channel memory controller. Each request address is turned into a target channel (A or B) and an address inside that channel. The mapping depends on a mode select and on the capacity of each channel. Capacities are given in 64-byte lines and are held steady as configuration while traffic flows.

Three arrangements are offered:
- **Interleaved:** adjacent 64-byte lines alternate between the channels, so two neighbouring lines are always served by different channels.
- **Sequential:** channel B is filled from its bottom to its top before channel A is used.
- **Mixed:** an interleaved zone sized at twice the smaller capacity sits at the bottom. The rest of the larger channel follows it as a linear single-channel region.

The results are registered and appear one clock after a valid request. Requests beyond the populated space raise an out-of-range flag instead of a translation.

Top module: `amap_top`

## Requirements
- R1: After reset, o_vld, o_oor, o_ch and o_addr are all zero.
- R2: o_vld is high exactly in the cycle after a cycle with i_vld high, and all outputs for a request appear with one clock of latency.
- R3: Inside the interleaved zone, address bit 6 picks the channel (0 gives channel A, o_ch=0; 1 gives channel B, o_ch=1). The channel-local address is the request with bit 6 removed and the bits above it shifted down by one.
- R4: In mixed mode (i_mode=2), the interleaved zone covers line indices below twice the smaller capacity. Higher lines go to the larger channel (channel A when the capacities are equal) at local line index = line − smaller capacity.
- R5: In interleaved mode (i_mode=0), with both channels populated, lines at or above twice the smaller capacity are out of range.
- R6: In sequential mode (i_mode=1), lines below cap_b go to channel B at the same line index. Lines from cap_b up to cap_a+cap_b go to channel A at line index − cap_b.
- R7: If one capacity is zero, every in-range address goes to the other channel with the local address equal to the request, in every mode. If both are zero, every address is out of range.
- R8: A valid request whose line index is at or above the usable limit sets o_oor. The usable limit is cap_a+cap_b, or the R5 limit in interleaved mode. o_ch and o_addr then keep their previous values.
- R9: Byte offset bits [5:0] of an in-range request pass unchanged into o_addr[5:0].
- R10: A cycle with i_vld low gives o_vld=0 and o_oor=0 in the next cycle, and o_ch and o_addr hold.
- R11: Mode value 3 behaves exactly as interleaved mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_vld | input | 1 | Request valid |
| i_addr | input | ADDR_W | System byte address |
| i_mode | input | 2 | 0 interleaved, 1 sequential, 2 mixed, 3 interleaved |
| i_cap_a | input | CAP_W | Channel A capacity in 64-byte lines |
| i_cap_b | input | CAP_W | Channel B capacity in 64-byte lines |
| o_vld | output | 1 | Result valid |
| o_ch | output | 1 | Target channel, 0 = A, 1 = B |
| o_addr | output | ADDR_W | Channel-local byte address |
| o_oor | output | 1 | Request was out of range |

## Verification
The bench builds the mapper with a 16-bit address and 8-bit capacity fields. This gives 1024 line indices against at most 510 populated lines, so every zone boundary can be swept exhaustively. The out-of-range region above the populated space is also reachable in a few hundred cycles. Capacity pairs are chosen to cover equal, unequal in both directions, one-sided zero and all-zero cases. This exercises the larger-channel choice, the tie rule and the single-channel fallback under every mode code.

// File: rtl/amap_pkg.sv
package amap_pkg;
  typedef enum logic [1:0] {
    MAP_ILV     = 2'd0,
    MAP_SEQ     = 2'd1,
    MAP_MIX     = 2'd2,
    MAP_ILV_ALT = 2'd3
  } map_mode_e;

  localparam logic CH_A = 1'b0;
  localparam logic CH_B = 1'b1;
endpackage

// File: rtl/amap_rst_sync.sv
module amap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/amap_zone.sv
// Derives zone boundaries and limits from the configured capacities.
module amap_zone
  import amap_pkg::*;
#(
  parameter int CAP_W = 25,
  parameter int SUM_W = 28
) (
  input  logic [1:0]       mode,
  input  logic [CAP_W-1:0] cap_a,
  input  logic [CAP_W-1:0] cap_b,
  output logic             seq_en,
  output logic [SUM_W-1:0] zone_lim,
  output logic [SUM_W-1:0] top_lim,
  output logic [SUM_W-1:0] min_cap,
  output logic [SUM_W-1:0] split,
  output logic             big_ch
);
  map_mode_e        mode_e;
  logic [SUM_W-1:0] a_x;
  logic [SUM_W-1:0] b_x;
  logic [SUM_W-1:0] sum;

  always_comb begin
    mode_e   = map_mode_e'(mode);
    a_x      = SUM_W'(cap_a);
    b_x      = SUM_W'(cap_b);
    min_cap  = (a_x < b_x) ? a_x : b_x;
    sum      = a_x + b_x;
    zone_lim = min_cap << 1;
    big_ch   = (a_x >= b_x) ? CH_A : CH_B;
    split    = b_x;
    seq_en   = (mode_e == MAP_SEQ);
    case (mode_e)
      MAP_SEQ, MAP_MIX: top_lim = sum;
      default:          top_lim = (min_cap == '0) ? sum : zone_lim;
    endcase
  end
endmodule

// File: rtl/amap_xlate.sv
// Translates a line index into channel, local line index and range flag.
module amap_xlate
  import amap_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int SUM_W  = 28
) (
  input  logic [LINE_W-1:0] line,
  input  logic              seq_en,
  input  logic [SUM_W-1:0]  zone_lim,
  input  logic [SUM_W-1:0]  top_lim,
  input  logic [SUM_W-1:0]  min_cap,
  input  logic [SUM_W-1:0]  split,
  input  logic              big_ch,
  output logic              ch,
  output logic [LINE_W-1:0] loc,
  output logic              oor
);
  logic [SUM_W-1:0] line_x;
  logic [SUM_W-1:0] diff;

  always_comb begin
    line_x = SUM_W'(line);
    oor    = (line_x >= top_lim);
    ch     = CH_A;
    diff   = '0;
    if (seq_en) begin
      if (line_x < split) begin
        ch   = CH_B;
        diff = line_x;
      end else begin
        ch   = CH_A;
        diff = line_x - split;
      end
    end else if (line_x < zone_lim) begin
      ch   = line[0];
      diff = line_x >> 1;
    end else begin
      ch   = big_ch;
      diff = line_x - min_cap;
    end
    loc = LINE_W'(diff);
  end
endmodule

// File: rtl/amap_top.sv
module amap_top
  import amap_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_LG2 = 6,
  parameter int CAP_W    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_vld,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic [1:0]        i_mode,
  input  logic [CAP_W-1:0]  i_cap_a,
  input  logic [CAP_W-1:0]  i_cap_b,
  output logic              o_vld,
  output logic              o_ch,
  output logic [ADDR_W-1:0] o_addr,
  output logic              o_oor
);
  localparam int LINE_W = ADDR_W - LINE_LG2;
  localparam int SUM_W  = ((LINE_W > CAP_W) ? LINE_W : CAP_W) + 2;

  logic              rst_sync_n;
  logic              seq_en;
  logic              big_ch;
  logic [SUM_W-1:0]  zone_lim;
  logic [SUM_W-1:0]  top_lim;
  logic [SUM_W-1:0]  min_cap;
  logic [SUM_W-1:0]  split;
  logic              x_ch;
  logic              x_oor;
  logic [LINE_W-1:0] x_loc;

  logic              vld_q,  vld_d;
  logic              oor_q,  oor_d;
  logic              ch_q,   ch_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              upd_en;

  amap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  amap_zone #(.CAP_W(CAP_W), .SUM_W(SUM_W)) u_zone (
    .mode     (i_mode),
    .cap_a    (i_cap_a),
    .cap_b    (i_cap_b),
    .seq_en   (seq_en),
    .zone_lim (zone_lim),
    .top_lim  (top_lim),
    .min_cap  (min_cap),
    .split    (split),
    .big_ch   (big_ch)
  );

  amap_xlate #(.LINE_W(LINE_W), .SUM_W(SUM_W)) u_xlate (
    .line     (i_addr[ADDR_W-1:LINE_LG2]),
    .seq_en   (seq_en),
    .zone_lim (zone_lim),
    .top_lim  (top_lim),
    .min_cap  (min_cap),
    .split    (split),
    .big_ch   (big_ch),
    .ch       (x_ch),
    .loc      (x_loc),
    .oor      (x_oor)
  );

  // Next-state
  always_comb begin
    upd_en = i_vld & ~x_oor;
    vld_d  = i_vld;
    oor_d  = i_vld & x_oor;
    ch_d   = upd_en ? x_ch : ch_q;
    addr_d = upd_en ? {x_loc, i_addr[LINE_LG2-1:0]} : addr_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      oor_q  <= 1'b0;
      ch_q   <= CH_A;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      oor_q  <= oor_d;
      ch_q   <= ch_d;
      addr_q <= addr_d;
    end
  end

  assign o_vld  = vld_q;
  assign o_oor  = oor_q;
  assign o_ch   = ch_q;
  assign o_addr = addr_q;
endmodule

// File: rtl/amap_chk.sv
module amap_chk #(
  parameter int ADDR_W   = 32,
  parameter int LINE_LG2 = 6,
  parameter int CAP_W    = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_vld,
  input logic [ADDR_W-1:0] i_addr,
  input logic [1:0]        i_mode,
  input logic [CAP_W-1:0]  i_cap_a,
  input logic [CAP_W-1:0]  i_cap_b,
  input logic              o_vld,
  input logic              o_ch,
  input logic [ADDR_W-1:0] o_addr,
  input logic              o_oor
);
  localparam int W = ADDR_W + CAP_W + 2;

  logic [W-1:0] req_line;
  logic [W-1:0] out_line;
  logic [W-1:0] cap_sum;
  logic [W-1:0] sel_cap;

  always_comb begin
    req_line = W'(i_addr >> LINE_LG2);
    out_line = W'(o_addr >> LINE_LG2);
    cap_sum  = W'(i_cap_a) + W'(i_cap_b);
    sel_cap  = o_ch ? W'(i_cap_b) : W'(i_cap_a);
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_vld |=> o_vld);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !i_vld |=> (!o_vld && !o_oor && $stable(o_ch) && $stable(o_addr)));

  // R8
  oor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && o_oor) |-> ($stable(o_ch) && $stable(o_addr)));

  // R8
  oor_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && req_line >= cap_sum) |=> o_oor);

  // R9
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_vld |=> (o_oor || o_addr[LINE_LG2-1:0] == $past(i_addr[LINE_LG2-1:0])));

  // R6
  seq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && i_mode == 2'd1 && req_line < W'(i_cap_b)) |=> (o_ch && !o_oor));

  // R4
  local_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && !o_oor) |-> (out_line < sel_cap));
endmodule

bind amap_top amap_chk #(
  .ADDR_W   (ADDR_W),
  .LINE_LG2 (LINE_LG2),
  .CAP_W    (CAP_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .i_vld   (i_vld),
  .i_addr  (i_addr),
  .i_mode  (i_mode),
  .i_cap_a (i_cap_a),
  .i_cap_b (i_cap_b),
  .o_vld   (o_vld),
  .o_ch    (o_ch),
  .o_addr  (o_addr),
  .o_oor   (o_oor)
);

// File: tb/tb_amap_top.sv
`timescale 1ns/1ps
module tb_amap_top;
  localparam int ADDR_W   = 16;
  localparam int LINE_LG2 = 6;
  localparam int CAP_W    = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              i_vld;
  logic [ADDR_W-1:0] i_addr;
  logic [1:0]        i_mode;
  logic [CAP_W-1:0]  i_cap_a;
  logic [CAP_W-1:0]  i_cap_b;
  logic              o_vld;
  logic              o_ch;
  logic [ADDR_W-1:0] o_addr;
  logic              o_oor;

  always #4 clk = ~clk;

  amap_top #(.ADDR_W(ADDR_W), .LINE_LG2(LINE_LG2), .CAP_W(CAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_addr(i_addr), .i_mode(i_mode),
    .i_cap_a(i_cap_a), .i_cap_b(i_cap_b), .o_vld(o_vld), .o_ch(o_ch),
    .o_addr(o_addr), .o_oor(o_oor)
  );

  int    vecs = 0;
  int    miss = 0;
  bit    done = 1'b0;
  int    m_vld = 0, m_oor = 0, m_ch = 0, m_addr = 0;
  string m_tag = "R1";

  // Behavioural reference: returns channel, local line and range flag.
  task automatic ref_map(input int mode, input int ca, input int cb, input int ln,
                         output int ch, output int loc, output int oor);
    int mn, lim;
    mn  = (ca < cb) ? ca : cb;
    ch  = 0;
    loc = 0;
    if (mode == 1) begin
      oor = (ln >= ca + cb) ? 1 : 0;
      if (ln < cb) begin ch = 1; loc = ln; end
      else begin ch = 0; loc = ln - cb; end
    end else begin
      lim = ((mode == 0 || mode == 3) && mn != 0) ? 2 * mn : ca + cb;
      oor = (ln >= lim) ? 1 : 0;
      if (ln < 2 * mn) begin ch = ln % 2; loc = ln / 2; end
      else begin ch = (ca >= cb) ? 0 : 1; loc = ln - mn; end
    end
  endtask

  task automatic step(input bit v, input int addr, input string tag);
    int ch, loc, oor;
    @(negedge clk);
    vecs++;
    if (o_vld !== 1'(m_vld) || o_oor !== 1'(m_oor) || o_ch !== 1'(m_ch) ||
        o_addr !== ADDR_W'(m_addr)) begin
      miss++;
      $display("FAIL %s: got vld=%0d oor=%0d ch=%0d addr=%0h expected vld=%0d oor=%0d ch=%0d addr=%0h",
               m_tag, o_vld, o_oor, o_ch, o_addr, m_vld, m_oor, m_ch, m_addr);
    end
    i_vld  = v;
    i_addr = ADDR_W'(addr);
    m_tag  = tag;
    m_vld  = v;
    m_oor  = 0;
    if (v) begin
      ref_map(int'(i_mode), int'(i_cap_a), int'(i_cap_b), addr / 64, ch, loc, oor);
      m_oor = oor;
      if (oor == 0) begin
        m_ch   = ch;
        m_addr = loc * 64 + addr % 64;
      end
    end
  endtask

  task automatic cfg(input int mode, input int ca, input int cb);
    step(1'b0, 0, "R10");
    @(negedge clk);
    vecs++;
    if (o_vld !== 1'b0 || o_oor !== 1'b0) begin
      miss++;
      $display("FAIL R10: got vld=%0d oor=%0d expected vld=0 oor=0", o_vld, o_oor);
    end
    i_mode  = 2'(mode);
    i_cap_a = CAP_W'(ca);
    i_cap_b = CAP_W'(cb);
    m_vld   = 0;
    m_oor   = 0;
    m_tag   = "R10";
  endtask

  task automatic sweep(input int first, input int last, input string tag);
    for (int l = first; l <= last; l++) step(1'b1, l * 64 + (l * 13) % 64, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; i_vld = 1'b0; i_addr = '0; i_mode = 2'd0;
    i_cap_a = '0; i_cap_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values compared on the first step
    step(1'b0, 0, "R1");
    step(1'b0, 0, "R1");

    // R3 and R5: equal capacities, whole space interleaved, then past the top
    cfg(0, 64, 64);
    sweep(0, 127, "R3");
    sweep(128, 131, "R5");

    // R2: valid requests separated by idle cycles
    for (int k = 0; k < 20; k++) begin
      step(1'b1, k * 64 + 5, "R2");
      step(1'b0, 0, "R10");
    end

    // R4: mixed mode, B larger then A larger, then equal (tie)
    cfg(2, 40, 100);
    sweep(0, 79, "R3");
    sweep(80, 139, "R4");
    sweep(140, 150, "R8");
    cfg(2, 100, 40);
    sweep(0, 150, "R4");
    cfg(2, 50, 50);
    sweep(95, 105, "R4");

    // R5: interleaved mode with unequal capacities
    cfg(0, 40, 100);
    sweep(0, 90, "R5");

    // R11: mode 3 matches interleaved mode
    cfg(3, 40, 100);
    sweep(0, 90, "R11");

    // R6: sequential, B first
    cfg(1, 30, 50);
    sweep(0, 90, "R6");
    cfg(1, 70, 10);
    sweep(0, 85, "R6");

    // R7: single populated channel and empty configuration
    cfg(2, 0, 70);
    sweep(0, 75, "R7");
    cfg(0, 70, 0);
    sweep(0, 75, "R7");
    cfg(1, 45, 0);
    sweep(0, 50, "R7");
    cfg(0, 0, 0);
    sweep(0, 5, "R7");

    // R9: varied byte offsets
    cfg(2, 20, 20);
    for (int o = 0; o < 64; o++) step(1'b1, (o % 40) * 64 + o, "R9");

    // R8: out-of-range request keeps the previous translation
    cfg(0, 16, 16);
    step(1'b1, 5 * 64 + 9, "R8");
    step(1'b1, 300 * 64 + 1, "R8");
    step(1'b1, 1000 * 64 + 2, "R8");
    step(1'b0, 0, "R10");
    step(1'b1, 31 * 64 + 63, "R8");
    step(1'b0, 0, "R10");
    step(1'b0, 0, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule